// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes finished Ethernet frames from a byte stream and stores them in host memory. Each frame goes into one receive descriptor, and the block then writes a status word back into that descriptor. A descriptor is four consecutive 32-bit words. Word 0 is the status, word 1 is the control word whose bits 10:0 give the buffer size in bytes, word 2 is the buffer byte address, and word 3 is the branch (the byte address of the next descriptor). The block reaches memory through a word-addressed request/grant port. For reads, data returns in the cycle after the grant. For writes, byte enables mark the lanes that are written.

Software writes the first descriptor's byte address into the pointer while the engine is idle, then pulses the poll input. The engine reads the four descriptor words and checks ownership. It then takes one frame, writes its bytes into the buffer, writes the status, follows the branch and prefetches the next descriptor at once. If it finds a descriptor that the controller does not own, it raises a no-buffer event and goes idle. While idle it drops every arriving frame whole until a poll demand arrives between frames.

The frame input is valid/ready. A byte transfers on a cycle with both high. The source holds the byte, last marker and flags stable while ready is low. Ready is low whenever the engine is using the memory port.

Top module: `rx_ring_writer`

## Requirements
- R1: On leaving idle, the engine reads descriptor words at word addresses P, P+1, P+2 and P+3 in that order, where P is the descriptor byte address divided by 4.
- R2: If status bit 31 of the fetched descriptor is 0, the engine reads no further words of it and writes nothing. It pulses `irq_no_buf` for one cycle and goes idle. In idle, frames are accepted and discarded whole.
- R3: Frame byte j is written to buffer word (buffer address / 4) + j/4, in byte lane j mod 4 (lane 0 = bits 7:0). Byte enables cover only the lanes that hold frame bytes.
- R4: The status writeback has bit 31 = 0 and bits 26:16 = the stored length. Bits 9 and 8 are 1, and bits 30:27, 14 and 10 are 0. Bit 15 is 1 exactly when no error bit is set.
- R5: The low status byte is built from the flags sampled with the last byte. `in_err` bit 0 (CRC) goes to status bit 1, bit 1 (alignment) to bit 2, and bit 2 (FIFO overflow) to bit 3. `in_err` bit 3 (runt) goes to status bit 5, bit 4 (system) to bit 6, and bit 5 (buffer underflow) to bit 7. Status bit 4 is the long-frame flag. Status bit 0 is the OR of status bits 7:1.
- R6: `in_cls` bit 0 (unicast match) goes to status bit 11, bit 1 (broadcast) to bit 12, and bit 2 (multicast) to bit 13.
- R7: Bytes beyond the control word's buffer size are not written. A frame with such bytes gets status bit 4 and bit 0 set, and its length field equals the buffer size. A frame exactly the buffer size is not long.
- R8: After the status write is granted, the next descriptor fetch uses the branch word as its address, so the ring can wrap.
- R9: `irq_rx_ok` pulses for one cycle once per frame whose status has bit 15 set, and never for a frame with errors.
- R10: `in_ready` is high only in the receive and idle states. It is never high in a cycle where `mem_req` is high, and a held byte is not lost.
- R11: A request held without grant keeps `mem_req`, `mem_we` and `mem_addr` stable until granted.
- R12: `cfg_desc_load` and `poll_demand` act only while idle. A poll that arrives during a dropped frame takes effect after that frame's last byte. Outside idle, both are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_desc_addr | input | 32 | Byte address of the first descriptor |
| cfg_desc_load | input | 1 | Load `cfg_desc_addr` into the current pointer (idle only) |
| poll_demand | input | 1 | Re-check ownership (idle only) |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Frame byte accepted this cycle when high with valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Last byte of the frame (FCS included) |
| in_err | input | 6 | Error flags, sampled with the last byte |
| in_cls | input | 3 | Address-class flags, sampled with the last byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 30 | Word address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid the cycle after a read grant |
| irq_rx_ok | output | 1 | One-cycle pulse per good frame |
| irq_no_buf | output | 1 | One-cycle pulse on finding a descriptor not owned |

## Verification
The status word and the last buffer word land in memory at most two granted writes after the last byte. `irq_rx_ok` rises in the cycle after the status write's grant. `irq_no_buf` rises the cycle after the status word is read back. The bench drives the grant randomly, so these delays vary. It therefore waits a fixed window of 60 cycles after each frame, well beyond the worst case at its grant rate, before it compares memory contents and interrupt counts. It samples interrupt pulses on the falling edge so that each one-cycle pulse is counted exactly once.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;

  typedef enum logic [2:0] {
    ST_WAIT  = 3'd0,
    ST_FETCH = 3'd1,
    ST_RECV  = 3'd2,
    ST_WDATA = 3'd3,
    ST_WSTAT = 3'd4
  } rxr_state_e;

  localparam int unsigned STAT_LEN_W = 11;

  // Builds the descriptor status word from the frame outcome.
  function automatic logic [31:0] rxr_status(
    input logic [STAT_LEN_W-1:0] len,
    input logic [5:0]            err,
    input logic                  trunc,
    input logic [2:0]            cls
  );
    logic [7:0]  lo;
    logic [31:0] w;
    lo[1] = err[0];
    lo[2] = err[1];
    lo[3] = err[2];
    lo[4] = trunc;
    lo[5] = err[3];
    lo[6] = err[4];
    lo[7] = err[5];
    lo[0] = |lo[7:1];
    w          = '0;
    w[26:16]   = len;
    w[15]      = ~lo[0];
    w[13:11]   = cls;
    w[9]       = 1'b1;
    w[8]       = 1'b1;
    w[7:0]     = lo;
    return w;
  endfunction

endpackage

// File: rtl/rxr_packer.sv
`timescale 1ns/1ps
module rxr_packer #(
  parameter int LANES = 4,
  parameter int FW    = $clog2(LANES+1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               push,
  input  logic [7:0]         din,
  output logic [8*LANES-1:0] word,
  output logic [LANES-1:0]   be,
  output logic [FW-1:0]      fill
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    fill <= '0;
    else if (clr)  fill <= '0;
    else if (push) fill <= fill + 1'b1;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       byte_q <= '0;
      else if (push && fill == FW'(l))  byte_q <= din;
    end
    assign word[8*l +: 8] = byte_q;
    assign be[l]          = FW'(l) < fill;
  end

  AST_PACK_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (fill < FW'(LANES))); // R3

endmodule

// File: rtl/rxr_ctrl.sv
`timescale 1ns/1ps
module rxr_ctrl import rxr_pkg::*; #(
  parameter int AW    = 32,
  parameter int LEN_W = 11,
  parameter int LANES = 4,
  parameter int FW    = $clog2(LANES+1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      cfg_desc_addr,
  input  logic               cfg_desc_load,
  input  logic               poll_demand,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_last,
  input  logic [5:0]         in_err,
  input  logic [2:0]         in_cls,
  output logic               mem_req,
  output logic               mem_we,
  output logic [AW-3:0]      mem_addr,
  output logic [LANES-1:0]   mem_be,
  output logic [8*LANES-1:0] mem_wdata,
  input  logic               mem_gnt,
  input  logic [8*LANES-1:0] mem_rdata,
  input  logic [8*LANES-1:0] pk_word,
  input  logic [LANES-1:0]   pk_be,
  input  logic [FW-1:0]      pk_fill,
  output logic               pk_push,
  output logic               pk_clr,
  output logic               irq_rx_ok,
  output logic               irq_no_buf
);

  localparam int WA = AW - 2;

  rxr_state_e        state;
  logic [AW-1:0]     cur_ptr, branch;
  logic [WA-1:0]     wptr;
  logic [1:0]        widx;
  logic              rd_pend;
  logic [LEN_W-1:0]  buf_size, nst;
  logic              trunc, last_seen, drop_mid, poll_pend;
  logic [5:0]        err_q;
  logic [2:0]        cls_q;
  logic              acc, store, good;

  assign good = ~(|err_q) & ~trunc;

  always_comb begin
    in_ready  = (state == ST_RECV) || (state == ST_WAIT);
    acc       = in_valid && in_ready;
    store     = nst < buf_size;
    pk_push   = (state == ST_RECV) && acc && store;
    pk_clr    = (state == ST_WDATA) && mem_gnt;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_ptr[AW-1:2];
    mem_be    = '0;
    mem_wdata = '0;
    case (state)
      ST_FETCH: begin
        mem_req  = !rd_pend;
        mem_addr = cur_ptr[AW-1:2] + WA'(widx);
      end
      ST_WDATA: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = wptr;
        mem_be    = pk_be;
        mem_wdata = pk_word;
      end
      ST_WSTAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_be    = '1;
        mem_wdata = rxr_status(STAT_LEN_W'(nst), err_q, trunc, cls_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_WAIT;
      cur_ptr    <= '0;
      branch     <= '0;
      wptr       <= '0;
      widx       <= '0;
      rd_pend    <= 1'b0;
      buf_size   <= '0;
      nst        <= '0;
      trunc      <= 1'b0;
      last_seen  <= 1'b0;
      drop_mid   <= 1'b0;
      poll_pend  <= 1'b0;
      err_q      <= '0;
      cls_q      <= '0;
      irq_rx_ok  <= 1'b0;
      irq_no_buf <= 1'b0;
    end else begin
      irq_rx_ok  <= 1'b0;
      irq_no_buf <= 1'b0;
      case (state)
        ST_WAIT: begin
          if (cfg_desc_load) cur_ptr <= cfg_desc_addr;
          if (acc) drop_mid <= !in_last;
          if ((poll_pend || poll_demand) && !drop_mid && !in_valid) begin
            state     <= ST_FETCH;
            widx      <= '0;
            rd_pend   <= 1'b0;
            poll_pend <= 1'b0;
          end else if (poll_demand) begin
            poll_pend <= 1'b1;
          end
        end
        ST_FETCH: begin
          if (rd_pend) begin
            rd_pend <= 1'b0;
            case (widx)
              2'd0: begin
                if (!mem_rdata[31]) begin
                  irq_no_buf <= 1'b1;
                  drop_mid   <= 1'b0;
                  state      <= ST_WAIT;
                end else begin
                  widx <= 2'd1;
                end
              end
              2'd1: begin
                buf_size <= mem_rdata[LEN_W-1:0];
                widx     <= 2'd2;
              end
              2'd2: begin
                wptr <= mem_rdata[AW-1:2];
                widx <= 2'd3;
              end
              default: begin
                branch    <= mem_rdata[AW-1:0];
                nst       <= '0;
                trunc     <= 1'b0;
                last_seen <= 1'b0;
                state     <= ST_RECV;
              end
            endcase
          end else if (mem_gnt) begin
            rd_pend <= 1'b1;
          end
        end
        ST_RECV: begin
          if (acc) begin
            if (store) nst <= nst + 1'b1;
            else       trunc <= 1'b1;
            if (in_last) begin
              err_q     <= in_err;
              cls_q     <= in_cls;
              last_seen <= 1'b1;
              state     <= (store || pk_fill != '0) ? ST_WDATA : ST_WSTAT;
            end else if (store && pk_fill == FW'(LANES-1)) begin
              state <= ST_WDATA;
            end
          end
        end
        ST_WDATA: begin
          if (mem_gnt) begin
            wptr  <= wptr + 1'b1;
            state <= last_seen ? ST_WSTAT : ST_RECV;
          end
        end
        ST_WSTAT: begin
          if (mem_gnt) begin
            irq_rx_ok <= good;
            cur_ptr   <= branch;
            widx      <= '0;
            rd_pend   <= 1'b0;
            state     <= ST_FETCH;
          end
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECV || state == ST_WDATA || state == ST_WSTAT) |-> (nst <= buf_size)); // R7

  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_rx_ok && irq_no_buf)); // R9

  AST_READY_PORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !mem_req); // R10

  AST_NOBUF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_no_buf |=> !irq_no_buf); // R2

endmodule

// File: rtl/rx_ring_writer.sv
`timescale 1ns/1ps
module rx_ring_writer #(
  parameter int AW    = 32,
  parameter int LEN_W = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_desc_addr,
  input  logic          cfg_desc_load,
  input  logic          poll_demand,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic [5:0]    in_err,
  input  logic [2:0]    in_cls,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-3:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic [31:0]   mem_rdata,
  output logic          irq_rx_ok,
  output logic          irq_no_buf
);

  localparam int LANES = 4;
  localparam int FW    = $clog2(LANES+1);

  logic [8*LANES-1:0] pk_word;
  logic [LANES-1:0]   pk_be;
  logic [FW-1:0]      pk_fill;
  logic               pk_push, pk_clr;

  rxr_packer #(.LANES(LANES), .FW(FW)) u_pack (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (pk_clr),
    .push (pk_push),
    .din  (in_data),
    .word (pk_word),
    .be   (pk_be),
    .fill (pk_fill)
  );

  rxr_ctrl #(.AW(AW), .LEN_W(LEN_W), .LANES(LANES), .FW(FW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_desc_addr(cfg_desc_addr),
    .cfg_desc_load(cfg_desc_load),
    .poll_demand  (poll_demand),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_last      (in_last),
    .in_err       (in_err),
    .in_cls       (in_cls),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_be       (mem_be),
    .mem_wdata    (mem_wdata),
    .mem_gnt      (mem_gnt),
    .mem_rdata    (mem_rdata),
    .pk_word      (pk_word),
    .pk_be        (pk_be),
    .pk_fill      (pk_fill),
    .pk_push      (pk_push),
    .pk_clr       (pk_clr),
    .irq_rx_ok    (irq_rx_ok),
    .irq_no_buf   (irq_no_buf)
  );

endmodule

// File: tb/sim_rx_ring_writer.sv
`timescale 1ns/1ps
module sim_rx_ring_writer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_desc_addr = '0;
  logic        cfg_desc_load = 1'b0;
  logic        poll_demand = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic [5:0]  in_err = '0;
  logic [2:0]  in_cls = '0;
  logic        mem_req, mem_we;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_gnt = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        irq_rx_ok, irq_no_buf;

  always #2.5 clk = ~clk;

  rx_ring_writer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_desc_addr(cfg_desc_addr), .cfg_desc_load(cfg_desc_load),
    .poll_demand(poll_demand), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_err(in_err), .in_cls(in_cls), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rdata(mem_rdata), .irq_rx_ok(irq_rx_ok), .irq_no_buf(irq_no_buf)
  );

  int tests = 0, fails = 0;
  int n_ok = 0, n_nobuf = 0;
  int rd_cnt = 0;
  int rd_hist [0:3];
  int hold_bad = 0, busy_bad = 0;
  int cyc = 0;
  logic        hold_pend = 1'b0;
  logic [29:0] hold_addr;
  logic        hold_we;
  logic [31:0] mem [0:1023];
  logic [7:0]  fb [0:255];
  int          bsz_of [0:3];

  // Memory model and port monitors
  always @(posedge clk) begin
    if (rst_n) begin
      if (hold_pend && !(mem_req && mem_addr == hold_addr && mem_we == hold_we)) hold_bad++;
      if (mem_req && in_ready) busy_bad++;
      hold_pend = mem_req && !mem_gnt;
      hold_addr = mem_addr;
      hold_we   = mem_we;
      if (mem_req && mem_gnt) begin
        if (mem_we) begin
          for (int k = 0; k < 4; k++)
            if (mem_be[k]) mem[mem_addr[9:0]][8*k +: 8] = mem_wdata[8*k +: 8];
        end else begin
          mem_rdata <= mem[mem_addr[9:0]];
          rd_hist[rd_cnt % 4] = int'(mem_addr);
          rd_cnt++;
        end
      end
    end
  end

  always @(negedge clk) begin
    mem_gnt <= ($urandom % 4) != 0;
    if (irq_rx_ok)  n_ok++;
    if (irq_no_buf) n_nobuf++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int dw(input int i); return 64 + 4 * i; endfunction
  function automatic int bw(input int i); return 256 + 128 * i; endfunction

  task automatic arm(input int i, input int bsz);
    mem[dw(i)]     = 32'h8000_0000;
    mem[dw(i) + 1] = bsz;
    mem[dw(i) + 2] = bw(i) * 4;
    mem[dw(i) + 3] = dw((i + 1) % 4) * 4;
    for (int w = 0; w < 128; w++) mem[bw(i) + w] = 32'hA5A5_A5A5;
    bsz_of[i] = bsz;
  endtask

  function automatic logic [31:0] exp_stat(input int len, input int bsz,
                                           input logic [5:0] e, input logic [2:0] c);
    int st;
    logic tr;
    logic [7:0] lo;
    logic [31:0] r;
    st = (len < bsz) ? len : bsz;
    tr = len > bsz;
    lo[1] = e[0]; lo[2] = e[1]; lo[3] = e[2]; lo[4] = tr;
    lo[5] = e[3]; lo[6] = e[4]; lo[7] = e[5];
    lo[0] = |lo[7:1];
    r = '0;
    r[26:16] = st[10:0];
    r[15] = !lo[0];
    r[13] = c[2]; r[12] = c[1]; r[11] = c[0];
    r[9] = 1'b1; r[8] = 1'b1;
    r[7:0] = lo;
    return r;
  endfunction

  task automatic send_frame(input int len, input logic [5:0] e, input logic [2:0] c,
                            input int poll_at);
    for (int i = 0; i < len; i++) begin
      logic ok;
      @(negedge clk);
      in_valid = 1'b1; in_data = fb[i]; in_last = (i == len - 1);
      in_err = e; in_cls = c; poll_demand = (i == poll_at);
      ok = 1'b0;
      while (!ok) begin
        ok = in_ready;
        @(posedge clk);
        if (!ok) @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; poll_demand = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_frame(input int i, input int len, input logic [5:0] e,
                             input logic [2:0] c, input int ok_before);
    logic [31:0] es, st, ew;
    int stored, bsz;
    repeat (60) @(negedge clk);
    bsz = bsz_of[i];
    es = exp_stat(len, bsz, e, c);
    st = mem[dw(i)];
    stored = (len < bsz) ? len : bsz;
    chk("R8 descriptor released", {31'd0, st[31]}, 32'd0);
    chk("R4 length and markers", st & 32'h07FF_C700, es & 32'h07FF_C700);
    chk("R5 error byte", {24'd0, st[7:0]}, {24'd0, es[7:0]});
    chk("R6 class bits", {29'd0, st[13:11]}, {29'd0, es[13:11]});
    if (len > bsz) chk("R7 truncated length", {21'd0, st[26:16]}, bsz);
    for (int w = 0; w <= (bsz + 3) / 4; w++) begin
      for (int l = 0; l < 4; l++)
        ew[8*l +: 8] = (4 * w + l < stored) ? fb[4 * w + l] : 8'hA5;
      chk("R3 buffer word", mem[bw(i) + w], ew);
    end
    chk("R9 ok pulses", n_ok - ok_before, es[15] ? 1 : 0);
  endtask

  initial begin
    int idx, len, bsz, okb;
    logic [5:0] e;
    logic [2:0] c;
    void'($urandom(32'd20240611));
    for (int w = 0; w < 1024; w++) mem[w] = '0;
    for (int i = 0; i < 4; i++) arm(i, 24 + 8 * i);
    mem[dw(0)] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ready in idle after reset", {31'd0, in_ready}, 32'd1);
    chk("R12 no request after reset", {31'd0, mem_req}, 32'd0);
    chk("R9 no ok pulse after reset", {31'd0, irq_rx_ok}, 32'd0);

    // Load pointer and poll: descriptor 0 not owned
    cfg_desc_addr = 32'h100; cfg_desc_load = 1'b1; poll_demand = 1'b1;
    @(negedge clk);
    cfg_desc_load = 1'b0; poll_demand = 1'b0;
    repeat (30) @(negedge clk);
    chk("R2 no-buffer pulse", n_nobuf, 1);
    chk("R2 only status word read", rd_cnt, 1);
    chk("R1 status word address", rd_hist[0], dw(0));

    // Frame dropped while idle; poll arrives mid-frame
    mem[dw(0)] = 32'h8000_0000;
    for (int i = 0; i < 10; i++) fb[i] = 8'(i + 1);
    okb = n_ok;
    send_frame(10, 6'd0, 3'b001, 3);
    repeat (40) @(negedge clk);
    chk("R2 dropped frame leaves status", mem[dw(0)], 32'h8000_0000);
    chk("R2 dropped frame leaves buffer", mem[bw(0)], 32'hA5A5_A5A5);
    chk("R2 no ok pulse for dropped frame", n_ok - okb, 0);
    chk("R12 delayed poll fetched", rd_cnt, 5);
    for (int k = 0; k < 4; k++)
      chk("R1 fetch order", rd_hist[(1 + k) % 4], dw(0) + k);

    // Random and directed frames around the ring
    for (int k = 0; k < 30; k++) begin
      idx = k % 4;
      bsz = bsz_of[idx];
      case (k % 5)
        0: len = bsz;
        1: len = bsz + 1;
        2: len = 1;
        3: len = 1 + ($urandom % 100);
        default: len = 4 * (1 + ($urandom % 20));
      endcase
      e = (($urandom % 4) == 0) ? 6'($urandom % 64) : 6'd0;
      case ($urandom % 3)
        0: c = 3'b001;
        1: c = 3'b010;
        default: c = 3'b100;
      endcase
      for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
      if (k == 20) begin
        // R12: load and poll while a descriptor is held must be ignored
        @(negedge clk);
        cfg_desc_addr = 32'h200; cfg_desc_load = 1'b1; poll_demand = 1'b1;
        @(negedge clk);
        cfg_desc_load = 1'b0; poll_demand = 1'b0;
      end
      okb = n_ok;
      send_frame(len, e, c, -1);
      check_frame(idx, len, e, c, okb);
      if (k == 20) chk("R12 load ignored while active", {31'd0, mem[dw(idx)][31]}, 32'd0);
      arm(idx, 8 + ($urandom % 73));
    end

    chk("R11 request held until grant", hold_bad, 0);
    chk("R10 ready never with request", busy_bad, 0);
    chk("R2 no extra no-buffer pulses", n_nobuf, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule